// File: doc/BRIEF.md
# Asynchronous Memory Write Strobe Sequencer

This block is a bus master that runs write cycles to asynchronous external memory or memory-mapped peripherals. An internal requester presents an address, write data and a request. The sequencer then drives the external address, a chip select, an active-low write strobe and an enable for the tri-state data bus. All edges are placed on a clock `clk_i` that runs at twice the core clock. One `clk_i` period is one "tick", which is half a core period. Core clock edges fall on ticks where an internal phase toggle is low, and requests are accepted only on those ticks.

The strobe-low time is two ticks per core period. It is one core period plus one core period for each programmed wait state. After the wait states have expired, the external acknowledge is sampled once per core period. Each sample that finds it low extends the strobe by one more core period. Two enable bits control the trailing edge of each write. One adds an address-hold period, during which address, select and data stay driven after the strobe rises. The other adds a bus-idle period with the bus released before the sequencer reports completion.

The wait count and both enable bits are captured when a request is accepted. A one-tick `done_o` pulse marks the point at which the bus is free again.

Top module: `async_wr_seq`

## Requirements
- R1: Select and address are driven for exactly one tick with the strobe high before the strobe falls, and the strobe is low only while select is high.
- R2: With acknowledge high, the strobe stays low for 2*(W+1) ticks, where W is the value on `cfg_wait_i` at acceptance.
- R3: Acknowledge is ignored while the programmed wait states are still being counted: holding it low only during the first 2*(W+1)-1 strobe ticks leaves the width at 2*(W+1).
- R4: From tick 2*(W+1) of the strobe on, acknowledge is sampled every second tick, and each low sample adds 2 ticks of strobe-low time. This includes the first sample when W=0.
- R5: The data enable rises one tick after the strobe falls and stays high through the tick after the strobe rises. `mem_addr_o` and `mem_data_o` carry the accepted address and data.
- R6: With `cfg_hold_i`=1, select and data enable stay high for 3 ticks after the strobe rises instead of 1.
- R7: With `cfg_idle_i`=1, the sequencer stays busy for 2 more ticks with select and data enable low before `done_o`. Without it, there are 0 such ticks.
- R8: With requests held back to back, the strobe-high time between two writes is 4 ticks, plus 2 ticks for each enabled hold or idle option.
- R9: Changes to `cfg_wait_i`, `cfg_hold_i` or `cfg_idle_i` after acceptance have no effect on the access in progress.
- R10: `busy_o` is high from the tick after acceptance until the access ends. `done_o` pulses for one tick with `busy_o` low. Requests made while busy are ignored.
- R11: During reset the strobe is high, and select, data enable, `busy_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Tick clock, twice the core clock rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Write request from the internal side |
| addr_i | input | ADDR_W | Write address |
| data_i | input | DATA_W | Write data |
| cfg_wait_i | input | 5 | Wait-state count W |
| cfg_hold_i | input | 1 | Enable for the address-hold period |
| cfg_idle_i | input | 1 | Enable for the bus-idle period |
| ack_i | input | 1 | External acknowledge, low extends the strobe |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-tick completion pulse |
| mem_addr_o | output | ADDR_W | External address |
| mem_data_o | output | DATA_W | External write data |
| mem_data_oe_o | output | 1 | Data bus output enable |
| mem_sel_o | output | 1 | Chip select, active high |
| mem_we_no | output | 1 | Write strobe, active low |

## Verification
A corrupted tick counter or state shows up as a strobe width that differs from 2*(W+1+E) ticks. It becomes visible on the first strobe rise after the fault. A wrong acknowledge sampling point changes the width of only those accesses where acknowledge toggles near the end of the wait count, so directed acknowledge patterns target those boundaries. Faults in the trailing sequence appear within a few ticks of the strobe rise, as wrong select, data-enable or busy durations, or as a wrong gap to the next strobe in back-to-back traffic.

// File: rtl/amw_pkg.sv
package amw_pkg;
  localparam int unsigned WAIT_W = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STRB,
    ST_TAIL,
    ST_HOLD,
    ST_GAP
  } st_e;

  typedef struct packed {
    logic [WAIT_W-1:0] waits;
    logic              hold;
    logic              idle;
  } cfg_t;
endpackage

// File: rtl/amw_phase.sv
module amw_phase (
  input  logic clk_i,
  input  logic rst_ni,
  output logic core_edge_o
);
  logic ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= 1'b0;
    else         ph_q <= ~ph_q;
  end

  assign core_edge_o = ~ph_q;
endmodule

// File: rtl/amw_tick_cnt.sv
module amw_tick_cnt #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  input  logic             dec_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (load_i)              cnt_q <= val_i;
    else if (dec_i && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/async_wr_seq.sv
module async_wr_seq
  import amw_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [WAIT_W-1:0] cfg_wait_i,
  input  logic              cfg_hold_i,
  input  logic              cfg_idle_i,
  input  logic              ack_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o,
  output logic              mem_data_oe_o,
  output logic              mem_sel_o,
  output logic              mem_we_no
);
  localparam int unsigned CNT_W = WAIT_W + 1;
  localparam logic [CNT_W-1:0] ONE_PERIOD = {{(CNT_W-1){1'b0}}, 1'b1};

  st_e              st_q, st_d;
  cfg_t             cfg_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic             first_q, done_q;
  logic             core_edge, accept, finish;
  logic             tmr_load, tmr_dec, tmr_zero;
  logic [CNT_W-1:0] tmr_val;

  amw_phase u_phase (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .core_edge_o (core_edge)
  );

  amw_tick_cnt #(.CNT_W(CNT_W)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .dec_i  (tmr_dec),
    .zero_o (tmr_zero)
  );

  assign accept = (st_q == ST_IDLE) && req_i && core_edge;

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_dec  = 1'b0;
    tmr_val  = '0;
    finish   = 1'b0;
    unique case (st_q)
      ST_IDLE: if (accept) st_d = ST_SETUP;
      ST_SETUP: begin
        st_d     = ST_STRB;
        tmr_load = 1'b1;
        tmr_val  = {cfg_q.waits, 1'b1};   // 2*(W+1)-1
      end
      ST_STRB: begin
        if (!tmr_zero) tmr_dec = 1'b1;
        else if (!ack_i) begin            // extend by one core period
          tmr_load = 1'b1;
          tmr_val  = ONE_PERIOD;
        end else st_d = ST_TAIL;
      end
      ST_TAIL: begin
        if (cfg_q.hold) begin
          st_d = ST_HOLD; tmr_load = 1'b1; tmr_val = ONE_PERIOD;
        end else if (cfg_q.idle) begin
          st_d = ST_GAP;  tmr_load = 1'b1; tmr_val = ONE_PERIOD;
        end else begin
          st_d = ST_IDLE; finish = 1'b1;
        end
      end
      ST_HOLD: begin
        if (!tmr_zero) tmr_dec = 1'b1;
        else if (cfg_q.idle) begin
          st_d = ST_GAP; tmr_load = 1'b1; tmr_val = ONE_PERIOD;
        end else begin
          st_d = ST_IDLE; finish = 1'b1;
        end
      end
      ST_GAP: begin
        if (!tmr_zero) tmr_dec = 1'b1;
        else begin
          st_d = ST_IDLE; finish = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cfg_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      first_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      first_q <= (st_q == ST_SETUP);
      done_q  <= finish;
      if (accept) begin
        cfg_q  <= '{waits: cfg_wait_i, hold: cfg_hold_i, idle: cfg_idle_i};
        addr_q <= addr_i;
        data_q <= data_i;
      end
    end
  end

  assign busy_o        = (st_q != ST_IDLE);
  assign done_o        = done_q;
  assign mem_addr_o    = addr_q;
  assign mem_data_o    = data_q;
  assign mem_we_no     = (st_q != ST_STRB);
  assign mem_sel_o     = (st_q == ST_SETUP) || (st_q == ST_STRB) ||
                         (st_q == ST_TAIL)  || (st_q == ST_HOLD);
  assign mem_data_oe_o = ((st_q == ST_STRB) && !first_q) ||
                         (st_q == ST_TAIL) || (st_q == ST_HOLD);
endmodule

// File: rtl/async_wr_seq_chk.sv
module async_wr_seq_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_data_oe_o,
  input logic              mem_sel_o,
  input logic              mem_we_no
);
  a_r1_sel_leads_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_we_no) |-> $past(mem_sel_o));

  a_r1_we_needs_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> mem_sel_o);

  a_r5_oe_lags_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_we_no) |-> !mem_data_oe_o);

  a_r5_drive_after_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> (mem_data_oe_o && mem_sel_o));

  a_r2_min_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_we_no) |=> !mem_we_no);

  a_r5_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_sel_o && $past(mem_sel_o)) |-> $stable(mem_addr_o));

  a_r10_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r10_sel_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_sel_o |-> busy_o);
endmodule

bind async_wr_seq async_wr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .mem_addr_o    (mem_addr_o),
  .mem_data_oe_o (mem_data_oe_o),
  .mem_sel_o     (mem_sel_o),
  .mem_we_no     (mem_we_no)
);

// File: tb/async_wr_seq_tb.sv
`timescale 1ns/1ps
module async_wr_seq_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic [15:0] data_i = '0;
  logic [4:0]  cfg_wait_i = '0;
  logic        cfg_hold_i = 1'b0;
  logic        cfg_idle_i = 1'b0;
  logic        ack_i = 1'b1;
  logic        busy_o, done_o, mem_data_oe_o, mem_sel_o, mem_we_no;
  logic [15:0] mem_addr_o, mem_data_o;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  async_wr_seq u_dut (.*);

  // monitor state, sampled at negedge
  int  ack_lo = 0;
  int  lo_run = 0, lo_w = 0, oe_lag = 0, tail_sel = 0, tail_oe = 0;
  int  gap_run = 0, gap = 0, idle_run = 0, idle_n = 0, falls = 0, dones = 0;
  bit  lead_ok = 0, after_rise = 0;
  logic prev_we = 1'b1, prev_sel = 1'b0, prev2_sel = 1'b0, prev_oe = 1'b0;
  logic [15:0] cap_addr = '0, cap_data = '0;

  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (!mem_we_no) begin
        if (prev_we) begin
          falls++;
          lead_ok  = prev_sel && !prev2_sel;
          cap_addr = mem_addr_o;
          gap      = gap_run;
        end
        lo_run++;
      end else begin
        if (!prev_we) begin
          lo_w = lo_run; lo_run = 0; gap_run = 0;
          tail_sel = 0; tail_oe = 0; after_rise = 1;
        end
        gap_run++;
        if (!mem_sel_o) after_rise = 0;
        if (after_rise) begin
          if (mem_sel_o) tail_sel++;
          if (mem_data_oe_o) tail_oe++;
        end
      end
      if (mem_data_oe_o && !prev_oe) begin
        oe_lag = lo_run; cap_data = mem_data_o;
      end
      if (busy_o && !mem_sel_o) idle_run++;
      if (done_o) begin
        idle_n = idle_run; idle_run = 0; dones++;
      end
      prev2_sel = prev_sel; prev_sel = mem_sel_o;
      prev_we = mem_we_no; prev_oe = mem_data_oe_o;
      ack_i = !(!mem_we_no && lo_run <= ack_lo);
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic clear_stats();
    falls = 0; dones = 0; idle_run = 0; lead_ok = 0;
  endtask

  function automatic int exp_width(input int w, input int al);
    int k0 = 2 * (w + 1);
    return (al < k0) ? k0 : k0 + 2 * ((al - k0) / 2 + 1);
  endfunction

  task automatic t_reset();
    @(negedge clk_i);
    chk(mem_we_no == 1'b1, "R11 strobe", mem_we_no, 1);
    chk(mem_sel_o == 1'b0, "R11 select", mem_sel_o, 0);
    chk(mem_data_oe_o == 1'b0, "R11 data enable", mem_data_oe_o, 0);
    chk(busy_o == 1'b0 && done_o == 1'b0, "R11 busy/done", {busy_o, done_o}, 0);
  endtask

  task automatic xfer(input string tag, input int w, input bit h, input bit i,
                      input int al, input logic [15:0] a, input logic [15:0] d,
                      input bit mid_chg, input bit poke);
    clear_stats();
    ack_lo = al;
    @(negedge clk_i);
    cfg_wait_i = 5'(w); cfg_hold_i = h; cfg_idle_i = i;
    addr_i = a; data_i = d; req_i = 1'b1;
    while (!busy_o) @(negedge clk_i);
    req_i = 1'b0;
    if (mid_chg) begin
      cfg_wait_i = 5'(31 - w); cfg_hold_i = !h; cfg_idle_i = !i;
    end
    if (poke) begin
      addr_i = ~a; data_i = ~d; req_i = 1'b1;
      repeat (3) @(negedge clk_i);
      req_i = 1'b0;
    end
    while (!done_o) @(negedge clk_i);
    repeat (4) @(negedge clk_i);
    chk(lo_w == exp_width(w, al), {tag, " R2 strobe width"}, lo_w, exp_width(w, al));
    chk(lead_ok, {tag, " R1 select lead"}, lead_ok, 1);
    chk(oe_lag == 2, {tag, " R5 enable lag"}, oe_lag, 2);
    chk(tail_sel == (h ? 3 : 1), {tag, " R6 select tail"}, tail_sel, h ? 3 : 1);
    chk(tail_oe == (h ? 3 : 1), {tag, " R6 enable tail"}, tail_oe, h ? 3 : 1);
    chk(idle_n == (i ? 2 : 0), {tag, " R7 idle ticks"}, idle_n, i ? 2 : 0);
    chk(falls == 1 && dones == 1 && !busy_o, {tag, " R10 single access"}, falls, 1);
    chk(cap_addr == a, {tag, " R5 address"}, cap_addr, a);
    chk(cap_data == d, {tag, " R5 data"}, cap_data, d);
  endtask

  task automatic t_pair(input bit h, input bit i);
    int exp_gap = 4 + 2 * (int'(h) + int'(i));
    clear_stats();
    ack_lo = 0;
    @(negedge clk_i);
    cfg_wait_i = 5'd1; cfg_hold_i = h; cfg_idle_i = i;
    addr_i = 16'h0C0C; data_i = 16'h3333; req_i = 1'b1;
    while (falls < 2) @(negedge clk_i);
    req_i = 1'b0;
    while (dones < 2) @(negedge clk_i);
    repeat (4) @(negedge clk_i);
    chk(gap == exp_gap, "R8 back-to-back strobe gap", gap, exp_gap);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    t_reset();
    @(negedge clk_i) rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    xfer("R2 basic",    0, 0, 0, 0,  16'h1234, 16'hA5A5, 0, 0);
    xfer("R2 waits",    3, 0, 0, 0,  16'h00F1, 16'h5A5A, 0, 0);
    xfer("R2 maxwait", 31, 0, 0, 0,  16'hFFFF, 16'h0001, 0, 0);
    xfer("R3 ackearly", 3, 0, 0, 7,  16'h0101, 16'h0202, 0, 0);
    xfer("R4 ackfirst", 0, 0, 0, 2,  16'h0303, 16'h0404, 0, 0);
    xfer("R4 ackmulti", 2, 0, 0, 9,  16'h0505, 16'h0606, 0, 0);
    xfer("R6 hold",     1, 1, 0, 0,  16'h0707, 16'h0808, 0, 0);
    xfer("R7 idle",     1, 0, 1, 0,  16'h0909, 16'h0A0A, 0, 0);
    xfer("R6 R7 both",  2, 1, 1, 4,  16'h0B0B, 16'h1C1C, 0, 0);
    xfer("R9 midchg",   2, 0, 0, 0,  16'h2D2D, 16'h3E3E, 1, 0);
    xfer("R10 poke",    2, 0, 0, 0,  16'h4F4F, 16'h5050, 0, 1);
    t_pair(0, 0);
    t_pair(1, 0);
    t_pair(0, 1);
    t_pair(1, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule